// File: doc/BRIEF.md
# Voltage Scaling Ramp Controller with Fault Blanking

This block is the digital controller for one regulator's dynamic voltage scaling. Software writes a 4-bit target code, and each code stands for an output offset. The controller does not jump to the new code. It moves the reference code one step at a time, and a fixed number of timebase ticks passes between steps. When the code reaches the target, a done status rises. The analog reference converter and the window comparators lie outside the block. They take `cur_code` and return the over-voltage and under-voltage indications.

Over-voltage and under-voltage indications are ignored while a walk is in progress. They are also ignored for a settling window of ticks after done rises. After that window, a fault sets a sticky fault flag. A per-regulator select decides what else happens. In shutdown mode the fault also drops the regulator enable. In flag-only mode the enable stays high, and software decides what to do.

The target write, flag clear and enable set are single-cycle control strobes with no back-pressure. A write is always accepted in the cycle it is presented. All status outputs are plain levels.

Top module: `dvs_ramp_ctrl`

## Requirements
- R1: After reset, `cur_code` is 8, `reg_en` is 1, `fault_flag` is 0 and `dvs_done` is 1.
- R2: Code k stands for an offset of (-20 + 2.5·k) %. So code 0 is -20 %, code 8 is 0 % and code 15 is +17.5 %. While `cur_code` differs from the target, it moves by exactly one code toward the target once every STEP_TICKS (50) asserted `tick` cycles. It never changes in a cycle without `tick`.
- R3: A target write (`tgt_wr` high) clears `dvs_done` on the next edge. `dvs_done` returns to 1 one cycle after `cur_code` equals the target.
- R4: While `dvs_done` is 0, `ov_fault` and `uv_fault` have no effect on `fault_flag` or `reg_en`.
- R5: For SETTLE_TICKS (1000) ticks after `dvs_done` rises, faults are still ignored. After that window, faults are acted on.
- R6: With `resp_sel` = 0 (shutdown mode), an acted-on fault sets `fault_flag` and clears `reg_en` at the next edge.
- R7: With `resp_sel` = 1 (flag-only mode), an acted-on fault sets the same `fault_flag` and leaves `reg_en` unchanged.
- R8: `fault_flag` stays set until `flag_clr` is pulsed; a fault in the same cycle wins. Clearing the flag does not restore `reg_en`. Only `en_set` sets `reg_en` again.
- R9: A target write during a walk redirects the walk. The walk continues from the present `cur_code` toward the new target, and the step interval restarts at the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one cycle per microsecond |
| tgt_wr | input | 1 | Load `tgt_code` as the new target |
| tgt_code | input | 4 | Target offset code |
| resp_sel | input | 1 | Fault response: 0 shutdown, 1 flag-only |
| ov_fault | input | 1 | Over-voltage indication |
| uv_fault | input | 1 | Under-voltage indication |
| flag_clr | input | 1 | Write-one-to-clear for `fault_flag` |
| en_set | input | 1 | Re-enable the regulator output |
| cur_code | output | 4 | Present reference offset code |
| reg_en | output | 1 | Regulator output enable |
| fault_flag | output | 1 | Sticky fault flag |
| dvs_done | output | 1 | Target reached |

## Verification
Some properties are checked on every cycle:
- `cur_code` moves by at most one code, and only on a tick.
- `dvs_done` is high only at the target.
- The blanking mask is high whenever a walk is running and in the cycle where done rises.
- A masked fault never raises the flag.
- Shutdown mode drops the enable, and flag-only mode keeps it.
- The flag and a dropped enable both hold until their own strobes.

Other behaviour can only be shown by the bench's scenarios, because it depends on exact counts:
- the 50-tick spacing of the steps;
- the exact end of the 1000-tick settling window;
- redirection from a mid-walk code;
- the walks to both ends of the code range.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

  typedef enum logic {
    RESP_SHUTDOWN  = 1'b0,
    RESP_FLAG_ONLY = 1'b1
  } resp_e;

  localparam int unsigned ZERO_OFFSET_CODE = 8;

endpackage

// File: rtl/dvs_stepper.sv
module dvs_stepper #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned STEP_TICKS = 50,
  parameter int unsigned RESET_CODE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tgt_wr,
  input  logic [CODE_W-1:0] tgt_code,
  output logic [CODE_W-1:0] cur_code,
  output logic              walking,
  output logic              done
);

  localparam int unsigned CNT_W = $clog2(STEP_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEP_TICKS - 1);
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] cur_q, tgt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              go_up;

  assign go_up    = (cur_q < tgt_q);
  assign walking  = (cur_q != tgt_q);
  assign cur_code = cur_q;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= RST_CODE;
      tgt_q  <= RST_CODE;
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (tgt_wr) begin
      // redirect: keep cur_q, restart interval (R9)
      tgt_q  <= tgt_code;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cur_q == tgt_q);
      if (walking && tick) begin
        if (cnt_q == LAST_CNT) begin
          cnt_q <= '0;
          cur_q <= go_up ? cur_q + 1'b1 : cur_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |->
      ((cur_q == $past(cur_q) + 1'b1) || (cur_q == $past(cur_q) - 1'b1)));

  p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q != $past(cur_q)) |-> $past(tick));

  p_done_at_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cur_q == tgt_q));

  p_write_clears_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr |=> !done_q);

endmodule

// File: rtl/fault_blanker.sv
module fault_blanker #(
  parameter int unsigned SETTLE_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic walking,
  input  logic done,
  output logic mask
);

  localparam int unsigned SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_TICKS);

  logic          done_prev_q;
  logic [SW-1:0] settle_q;
  logic          start;

  assign start = done & ~done_prev_q;
  assign mask  = walking | ~done | start | (settle_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_prev_q <= 1'b1;
      settle_q    <= '0;
    end else begin
      done_prev_q <= done;
      if (!done) begin
        settle_q <= '0;
      end else if (start) begin
        settle_q <= SETTLE_LOAD;
      end else if (tick && settle_q != '0) begin
        settle_q <= settle_q - 1'b1;
      end
    end
  end

  p_mask_while_walking_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walking |-> mask);

  p_settle_counts_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q != '0 && done && !$past(start)) |-> (settle_q <= $past(settle_q)));

endmodule

// File: rtl/fault_responder.sv
module fault_responder
  import dvs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault_in,
  input  logic mask,
  input  logic resp_sel,
  input  logic flag_clr,
  input  logic en_set,
  output logic reg_en,
  output logic flag
);

  resp_e mode;
  logic  hit;
  logic  en_q, flag_q;

  assign mode   = resp_e'(resp_sel);
  assign hit    = fault_in & ~mask;
  assign reg_en = en_q;
  assign flag   = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;

      if (hit && mode == RESP_SHUTDOWN) en_q <= 1'b0;
      else if (en_set)                  en_q <= 1'b1;
    end
  end

  p_masked_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && !flag_q) |=> !flag_q);

  p_resp_a_shutdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && !mask && !resp_sel) |=> (!en_q && flag_q));

  p_resp_b_keeps_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && !mask && resp_sel && en_q) |=> (en_q && flag_q));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  p_clear_no_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !en_set) |=> !en_q);

endmodule

// File: rtl/dvs_ramp_ctrl.sv
module dvs_ramp_ctrl #(
  parameter int unsigned CODE_W       = 4,
  parameter int unsigned STEP_TICKS   = 50,
  parameter int unsigned SETTLE_TICKS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tgt_wr,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic              resp_sel,
  input  logic              ov_fault,
  input  logic              uv_fault,
  input  logic              flag_clr,
  input  logic              en_set,
  output logic [CODE_W-1:0] cur_code,
  output logic              reg_en,
  output logic              fault_flag,
  output logic              dvs_done
);

  logic walking, mask;

  dvs_stepper #(
    .CODE_W     (CODE_W),
    .STEP_TICKS (STEP_TICKS),
    .RESET_CODE (dvs_pkg::ZERO_OFFSET_CODE)
  ) u_stepper (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .tgt_wr   (tgt_wr),
    .tgt_code (tgt_code),
    .cur_code (cur_code),
    .walking  (walking),
    .done     (dvs_done)
  );

  fault_blanker #(
    .SETTLE_TICKS (SETTLE_TICKS)
  ) u_blanker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .walking (walking),
    .done    (dvs_done),
    .mask    (mask)
  );

  fault_responder u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_in (ov_fault | uv_fault),
    .mask     (mask),
    .resp_sel (resp_sel),
    .flag_clr (flag_clr),
    .en_set   (en_set),
    .reg_en   (reg_en),
    .flag     (fault_flag)
  );

  p_mask_on_done_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_done && !$past(dvs_done)) |-> mask);

endmodule

// File: tb/dvs_ramp_ctrl_tb.sv
module dvs_ramp_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STEP = 50;
  localparam int SETTLE = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       tgt_wr = 1'b0;
  logic [3:0] tgt_code = 4'd0;
  logic       resp_sel = 1'b0;
  logic       ov_fault = 1'b0, uv_fault = 1'b0;
  logic       flag_clr = 1'b0, en_set = 1'b0;
  logic [3:0] cur_code;
  logic       reg_en, fault_flag, dvs_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    string      req;
    logic [3:0] code;
    logic       en;
    logic       flag;
    logic       done;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dvs_ramp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tgt_wr(tgt_wr), .tgt_code(tgt_code),
    .resp_sel(resp_sel), .ov_fault(ov_fault), .uv_fault(uv_fault),
    .flag_clr(flag_clr), .en_set(en_set), .cur_code(cur_code),
    .reg_en(reg_en), .fault_flag(fault_flag), .dvs_done(dvs_done)
  );

  function automatic logic [3:0] pct_code(int tenths);
    return 4'((tenths + 200) / 25);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(string req, logic [3:0] c, logic e, logic f, logic d);
    exp_t x;
    x.req = req; x.code = c; x.en = e; x.flag = f; x.done = d;
    sb.push_back(x);
  endtask

  task automatic write_tgt(logic [3:0] c);
    tgt_code = c; tgt_wr = 1'b1;
    cyc(1);
    tgt_wr = 1'b0;
  endtask

  task automatic pulse_fault(bit ov);
    if (ov) ov_fault = 1'b1; else uv_fault = 1'b1;
    cyc(1);
    ov_fault = 1'b0; uv_fault = 1'b0;
  endtask

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        checks++;
        if (cur_code !== x.code || reg_en !== x.en || fault_flag !== x.flag || dvs_done !== x.done) begin
          errors++;
          $display("FAIL %s: got code=%0d en=%b flag=%b done=%b, expected code=%0d en=%b flag=%b done=%b",
                   x.req, cur_code, reg_en, fault_flag, dvs_done, x.code, x.en, x.flag, x.done);
        end
      end
    end
  end

  initial begin
    int cnt = 0;
    while (!finished) begin
      @(posedge clk);
      cnt++;
      if (cnt > 200000) begin
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_st("R1 reset", 4'd8, 1, 0, 1);
    cyc(1);
    expect_st("R2 code 8 is 0%", pct_code(0), 1, 0, 1);

    // walk 8 -> 10 (+5%)
    write_tgt(pct_code(50));
    expect_st("R3 write clears done", 4'd8, 1, 0, 0);
    cyc(STEP - 1);
    expect_st("R2 no step before 50 ticks", 4'd8, 1, 0, 0);
    cyc(1);
    expect_st("R2 first step at 50 ticks", 4'd9, 1, 0, 0);
    cyc(9);
    ov_fault = 1'b1;
    cyc(5);
    ov_fault = 1'b0;
    expect_st("R4 fault ignored during walk", 4'd9, 1, 0, 0);
    cyc(STEP - 14);
    expect_st("R3 done low at arrival", 4'd10, 1, 0, 0);
    cyc(1);
    expect_st("R3 done one cycle after arrival", 4'd10, 1, 0, 1);

    // settling window
    cyc(500);
    pulse_fault(0);
    expect_st("R5 fault ignored in settling", 4'd10, 1, 0, 1);
    cyc(490);
    pulse_fault(1);
    expect_st("R5 fault ignored near window end", 4'd10, 1, 0, 1);
    cyc(20);
    resp_sel = 1'b0;
    pulse_fault(0);
    expect_st("R6 shutdown response", 4'd10, 0, 1, 1);

    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    expect_st("R8 clear keeps output off", 4'd10, 0, 0, 1);
    cyc(5);
    expect_st("R8 output stays off", 4'd10, 0, 0, 1);
    en_set = 1'b1; cyc(1); en_set = 1'b0;
    expect_st("R8 en_set re-enables", 4'd10, 1, 0, 1);

    resp_sel = 1'b1;
    pulse_fault(1);
    expect_st("R7 flag-only response", 4'd10, 1, 1, 1);
    cyc(10);
    expect_st("R8 flag sticky", 4'd10, 1, 1, 1);
    flag_clr = 1'b1; ov_fault = 1'b1; cyc(1); flag_clr = 1'b0; ov_fault = 1'b0;
    expect_st("R8 fault wins over clear", 4'd10, 1, 1, 1);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    expect_st("R8 flag cleared", 4'd10, 1, 0, 1);

    // tick gating and redirect
    write_tgt(4'd0);
    tick = 1'b0;
    cyc(120);
    expect_st("R2 no step without tick", 4'd10, 1, 0, 0);
    tick = 1'b1;
    cyc(2 * STEP);
    expect_st("R2 two steps down", 4'd8, 1, 0, 0);
    cyc(10);
    write_tgt(4'd12);
    cyc(STEP - 1);
    expect_st("R9 interval restarts at redirect", 4'd8, 1, 0, 0);
    cyc(1);
    expect_st("R9 walk reverses from current code", 4'd9, 1, 0, 0);
    cyc(3 * STEP);
    expect_st("R9 reaches new target", 4'd12, 1, 0, 0);
    cyc(1);
    expect_st("R3 done after redirect", 4'd12, 1, 0, 1);

    // same-target write
    write_tgt(4'd12);
    expect_st("R3 same-target write drops done", 4'd12, 1, 0, 0);
    cyc(1);
    expect_st("R3 done returns", 4'd12, 1, 0, 1);

    // full top of range
    write_tgt(pct_code(175));
    cyc(3 * STEP + 1);
    expect_st("R2 code 15 is +17.5%", 4'd15, 1, 0, 1);

    // full bottom of range
    write_tgt(pct_code(-200));
    cyc(15 * STEP + 1);
    expect_st("R2 code 0 is -20%", 4'd0, 1, 0, 1);
    resp_sel = 1'b0;
    cyc(SETTLE + 10);
    pulse_fault(1);
    expect_st("R6 shutdown after settle at bottom", 4'd0, 0, 1, 1);

    cyc(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule